// File: doc/BRIEF.md
# Ping-Pong Memory Address Sequencer

This block produces the memory-side byte address for a single DMA stream. Software programs two buffer base addresses, an item count and a mode word. When the stream is enabled, the block presents one address per beat on a valid/ready pair. Each accepted beat advances the address by the item size, or keeps it fixed when increment is off. After the programmed number of beats the buffer is complete. The block then does one of three things: it switches to the other buffer (ping-pong), it restarts the same buffer (circular), or it stops.

Ping-pong operation lets software refill one buffer while the stream works on the other. While the stream runs, the base address of the idle buffer stays writable. The base address of the active buffer is locked, and a write to it raises a sticky error. Every other setting can change only while the stream is stopped. The index of the buffer in use is always visible on `cur_tgt`.

Back-pressure: `addr_valid` is high exactly while the stream runs. A beat happens only on a clock edge where both `addr_valid` and `addr_ready` are high. While `addr_ready` is low, `mem_addr` holds its value.

Top module: `dbuf_addr_seq`

## Requirements
- R1: After reset, `addr_valid`, `cur_tgt`, `buf_done` and `cfg_err` are 0.
- R2: Setup uses `cfg_wr` with a selector in `cfg_sel`: 0 for buffer-0 base, 1 for buffer-1 base, 2 for item count, 3 for the mode word. While stopped, every write is accepted. The mode word has these fields: bit0 enable, bit1 circular, bit2 ping-pong, bits[4:3] direction (0 peripheral-to-memory, 1 memory-to-peripheral, 2 memory-to-memory), bit5 first buffer, bits[7:6] size code, bit8 increment. A mode write with enable=1 starts the stream only if the stored count is nonzero. The next cycle then shows `addr_valid`=1 and `mem_addr` equal to the base of the starting buffer.
- R3: On each beat, `mem_addr` grows by 1, 2 or 4 for size codes 0, 1 and 2/3 when increment is set, and by 0 otherwise. With `addr_ready` low, `mem_addr` holds.
- R4: In ping-pong operation, the beat that completes the count on buffer k is followed in the next cycle by `mem_addr` equal to the base of buffer 1-k and `cur_tgt`=1-k. There is no idle cycle between buffers.
- R5: Ping-pong operation requires circular=1 and a direction other than memory-to-memory. Otherwise the first-buffer field is ignored, the stream starts on buffer 0, and it never switches buffers.
- R6: In circular operation without ping-pong, the completing beat reloads `mem_addr` from the base of the same buffer.
- R7: With circular=0, the completing beat stops the stream, and `addr_valid` falls in the next cycle.
- R8: `buf_done` is high for exactly the one cycle after each completing beat, with `buf_done_idx` giving the buffer just finished.
- R9: While running, writes to the count and to all mode fields except enable are ignored. A mode write with enable=0 stops the stream.
- R10: While running in ping-pong operation, a write to the idle buffer's base is accepted and takes effect at the next switch. A write to the active buffer's base is ignored and sets `cfg_err`.
- R11: `cfg_err` stays set until `err_clr` is pulsed high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register selector |
| cfg_wdata | input | AW | Write data |
| err_clr | input | 1 | Clears the sticky config error |
| addr_ready | input | 1 | Consumer accepts the current address |
| addr_valid | output | 1 | Stream running, address valid |
| mem_addr | output | AW | Current memory byte address |
| cur_tgt | output | 1 | Buffer index in use |
| buf_done | output | 1 | One-cycle buffer-complete pulse |
| buf_done_idx | output | 1 | Index of the buffer just completed |
| cfg_err | output | 1 | Sticky blocked-write error |

## Verification
All results are registered, so each is due exactly one clock edge after its cause. After a configuration write, the new start state, a new base value or an error flag appears on the edge that samples the write. After a beat, the next address appears on the edge where valid and ready are both high. On a completing beat, `buf_done` and the reloaded address appear together in the following cycle. The bench changes inputs 1 ns after a rising edge, advances exactly one edge per expected result, and samples at that same offset. It relies on no settling delay beyond one edge.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  typedef enum logic [1:0] {
    DIR_P2M = 2'd0,
    DIR_M2P = 2'd1,
    DIR_M2M = 2'd2,
    DIR_RSV = 2'd3
  } dir_e;

  typedef struct packed {
    logic       minc;
    logic [1:0] size;
    logic       first;
    dir_e       dir;
    logic       pp;
    logic       circ;
    logic       en;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  localparam logic [1:0] SEL_BASE0 = 2'd0;
  localparam logic [1:0] SEL_BASE1 = 2'd1;
  localparam logic [1:0] SEL_COUNT = 2'd2;
  localparam logic [1:0] SEL_MODE  = 2'd3;

  function automatic logic pingpong_ok(mode_t m);
    return m.pp && m.circ && (m.dir != DIR_M2M);
  endfunction

  function automatic logic [2:0] step_bytes(mode_t m);
    if (!m.minc) return 3'd0;
    case (m.size)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/dbuf_cfg_regs.sv
module dbuf_cfg_regs
  import dbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  localparam int NBUF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              err_clr,
  input  logic              running,
  input  logic              cur_tgt,
  output logic [NBUF*AW-1:0] bases,
  output logic [CW-1:0]     count_q,
  output mode_t             mode_q,
  output logic              pp_live,
  output logic              start,
  output logic              start_tgt,
  output logic              stop,
  output logic              cfg_err
);
  mode_t wmode;
  logic  wr_mode;

  assign wmode   = mode_t'(cfg_wdata[MODE_W-1:0]);
  assign wr_mode = cfg_wr && (cfg_sel == SEL_MODE);
  assign pp_live = pingpong_ok(mode_q);

  assign start     = wr_mode && !running && wmode.en && (count_q != '0);
  assign start_tgt = pingpong_ok(wmode) ? wmode.first : 1'b0;
  assign stop      = wr_mode && running && !wmode.en;

  for (genvar g = 0; g < NBUF; g++) begin : g_base
    logic [AW-1:0] q;
    logic          hit;
    assign hit = cfg_wr && (cfg_sel == g[1:0]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (hit && (!running || (pp_live && (cur_tgt != g[0]))))
        q <= cfg_wdata;
    end
    assign bases[g*AW +: AW] = q;
  end

  logic blocked;
  assign blocked = cfg_wr && running && (cfg_sel[1] == 1'b0) && (cfg_sel[0] == cur_tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      mode_q  <= '0;
      cfg_err <= 1'b0;
    end else begin
      if (cfg_wr && !running && (cfg_sel == SEL_COUNT))
        count_q <= cfg_wdata[CW-1:0];
      if (wr_mode && !running)
        mode_q <= wmode;
      if (blocked)
        cfg_err <= 1'b1;
      else if (err_clr)
        cfg_err <= 1'b0;
    end
  end
endmodule

// File: rtl/dbuf_addr_gen.sv
module dbuf_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  localparam int NBUF = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               start_tgt,
  input  logic               stop,
  input  logic [NBUF*AW-1:0] bases,
  input  logic [CW-1:0]      count_q,
  input  logic [2:0]         step,
  input  logic               pp_live,
  input  logic               circ,
  input  logic               beat_rdy,
  output logic               running,
  output logic               cur_tgt,
  output logic [AW-1:0]      mem_addr,
  output logic               done,
  output logic               done_idx
);
  logic [CW-1:0] remain;
  logic          last;
  logic          other;

  assign last  = (remain == CW'(1));
  assign other = ~cur_tgt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      cur_tgt  <= 1'b0;
      mem_addr <= '0;
      remain   <= '0;
      done     <= 1'b0;
      done_idx <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        running  <= 1'b1;
        cur_tgt  <= start_tgt;
        mem_addr <= bases[start_tgt*AW +: AW];
        remain   <= count_q;
      end else if (stop) begin
        running <= 1'b0;
      end else if (running && beat_rdy) begin
        if (last) begin
          done     <= 1'b1;
          done_idx <= cur_tgt;
          remain   <= count_q;
          if (pp_live) begin
            cur_tgt  <= other;
            mem_addr <= bases[other*AW +: AW];
          end else if (circ) begin
            mem_addr <= bases[cur_tgt*AW +: AW];
          end else begin
            running <= 1'b0;
          end
        end else begin
          mem_addr <= mem_addr + AW'(step);
          remain   <= remain - CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dbuf_addr_seq.sv
module dbuf_addr_seq
  import dbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          err_clr,
  input  logic          addr_ready,
  output logic          addr_valid,
  output logic [AW-1:0] mem_addr,
  output logic          cur_tgt,
  output logic          buf_done,
  output logic          buf_done_idx,
  output logic          cfg_err
);
  localparam int NBUF = 2;

  logic [NBUF*AW-1:0] bases;
  logic [CW-1:0]      count_q;
  mode_t              mode_q;
  logic [MODE_W-1:0]  mode_bits;
  logic               pp_live, start, start_tgt, stop, running;

  assign mode_bits  = mode_q;
  assign addr_valid = running;

  dbuf_cfg_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .err_clr(err_clr), .running(running),
    .cur_tgt(cur_tgt), .bases(bases), .count_q(count_q), .mode_q(mode_q),
    .pp_live(pp_live), .start(start), .start_tgt(start_tgt), .stop(stop),
    .cfg_err(cfg_err)
  );

  dbuf_addr_gen #(.AW(AW), .CW(CW)) gen_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_tgt(start_tgt),
    .stop(stop), .bases(bases), .count_q(count_q),
    .step(step_bytes(mode_q)), .pp_live(pp_live), .circ(mode_q.circ),
    .beat_rdy(addr_ready), .running(running), .cur_tgt(cur_tgt),
    .mem_addr(mem_addr), .done(buf_done), .done_idx(buf_done_idx)
  );
endmodule

// File: rtl/dbuf_addr_seq_chk.sv
module dbuf_addr_seq_chk #(
  parameter int AW = 32,
  parameter int MW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] mem_addr,
  input logic          cur_tgt,
  input logic          buf_done,
  input logic          buf_done_idx,
  input logic          cfg_err,
  input logic          err_clr,
  input logic [MW-1:0] mode_bits
);
  AST_SWAP_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid) && !$stable(cur_tgt)) |-> (buf_done && buf_done_idx != cur_tgt)); // R4

  AST_M2M_NO_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid) && mode_bits[4:3] == 2'd2) |-> $stable(cur_tgt)); // R5

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid) && !$past(addr_ready)) |-> $stable(mem_addr)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_err) && !$past(err_clr)) |-> cfg_err); // R11

  AST_DONE_SINGLE_NO_CIRC: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_done && !mode_bits[1]) |-> !addr_valid); // R7
endmodule

bind dbuf_addr_seq dbuf_addr_seq_chk #(.AW(AW), .MW(dbuf_pkg::MODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .mem_addr(mem_addr), .cur_tgt(cur_tgt), .buf_done(buf_done),
  .buf_done_idx(buf_done_idx), .cfg_err(cfg_err), .err_clr(err_clr),
  .mode_bits(mode_bits)
);

// File: tb/dbuf_addr_seq_tb_top.sv
`timescale 1ns/1ps
module dbuf_addr_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        err_clr = 1'b0;
  logic        addr_ready = 1'b0;
  logic        addr_valid, cur_tgt, buf_done, buf_done_idx, cfg_err;
  logic [31:0] mem_addr;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dbuf_addr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .err_clr(err_clr), .addr_ready(addr_ready),
    .addr_valid(addr_valid), .mem_addr(mem_addr), .cur_tgt(cur_tgt),
    .buf_done(buf_done), .buf_done_idx(buf_done_idx), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] md(bit en, bit circ, bit pp, logic [1:0] dir,
                                     bit first, logic [1:0] sz, bit inc);
    return {23'd0, inc, sz, first, dir, pp, circ, en};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid", addr_valid, 0);
    chk("R1 tgt", cur_tgt, 0);
    chk("R1 done", buf_done, 0);
    chk("R1 err", cfg_err, 0);
  endtask

  task automatic t_pingpong();
    wr(2'd0, 32'h1000);
    wr(2'd1, 32'h2000);
    wr(2'd2, 32'd2);
    wr(2'd3, md(1, 1, 1, 2'd0, 1, 2'd1, 1));
    chk("R2 start valid", addr_valid, 1);
    chk("R2 start addr", mem_addr, 32'h2000);
    chk("R2 start tgt", cur_tgt, 1);
    addr_ready = 1'b1;
    tick();
    chk("R3 step2", mem_addr, 32'h2002);
    chk("R8 no early done", buf_done, 0);
    tick();
    chk("R4 swap addr", mem_addr, 32'h1000);
    chk("R4 swap tgt", cur_tgt, 0);
    chk("R8 done", buf_done, 1);
    chk("R8 done idx", buf_done_idx, 1);
    addr_ready = 1'b0;
    tick();
    chk("R8 one cycle", buf_done, 0);
    chk("R3 hold", mem_addr, 32'h1000);
    wr(2'd1, 32'h5000);
    chk("R10 idle write no err", cfg_err, 0);
    wr(2'd0, 32'h7000);
    chk("R10 active write err", cfg_err, 1);
    chk("R10 active addr kept", mem_addr, 32'h1000);
    wr(2'd2, 32'd5);
    wr(2'd3, md(1, 0, 0, 2'd2, 0, 2'd2, 0));
    chk("R9 still running", addr_valid, 1);
    addr_ready = 1'b1;
    tick();
    chk("R9 step unchanged", mem_addr, 32'h1002);
    tick();
    chk("R10 new idle base used", mem_addr, 32'h5000);
    chk("R9 count unchanged tgt", cur_tgt, 1);
    chk("R8 done idx0", buf_done_idx, 0);
    addr_ready = 1'b0;
    err_clr = 1'b1;
    tick();
    err_clr = 1'b0;
    chk("R11 cleared", cfg_err, 0);
    wr(2'd3, 32'd0);
    chk("R9 stop", addr_valid, 0);
  endtask

  task automatic t_m2m_circ();
    wr(2'd0, 32'h100);
    wr(2'd2, 32'd2);
    wr(2'd3, md(1, 1, 1, 2'd2, 1, 2'd0, 1));
    chk("R5 m2m starts buf0", cur_tgt, 0);
    chk("R5 m2m base0", mem_addr, 32'h100);
    addr_ready = 1'b1;
    tick();
    chk("R3 step1", mem_addr, 32'h101);
    tick();
    chk("R6 reload same base", mem_addr, 32'h100);
    chk("R5 no swap", cur_tgt, 0);
    chk("R8 done m2m", buf_done, 1);
    addr_ready = 1'b0;
    wr(2'd3, 32'd0);
  endtask

  task automatic t_single();
    wr(2'd3, md(1, 0, 1, 2'd0, 1, 2'd2, 0));
    chk("R5 no circ starts buf0", cur_tgt, 0);
    addr_ready = 1'b1;
    tick();
    chk("R3 no increment", mem_addr, 32'h100);
    chk("R7 running mid", addr_valid, 1);
    tick();
    chk("R7 stopped", addr_valid, 0);
    chk("R8 done single", buf_done, 1);
    addr_ready = 1'b0;
    tick();
    chk("R8 pulse ends", buf_done, 0);
  endtask

  task automatic t_zero_count();
    wr(2'd2, 32'd0);
    wr(2'd3, md(1, 1, 0, 2'd0, 0, 2'd0, 1));
    chk("R2 zero count no start", addr_valid, 0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_pingpong();
    t_m2m_circ();
    t_single();
    t_zero_count();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule